// File: doc/BRIEF.md
# Low-Power Mode Sequencing Controller

This block tracks the operating mode of a small processor subsystem across four states: normal-high, normal-low, doze-high and doze-low. Software arms a doze by writing a 2-bit low-power select field and a clock-source bit, then the core raises a power-down request. The block decides which doze mode applies, halts the core, and steers the system clock divider to the divide field that belongs to the current mode.

While dozing, the block watches for wake events. An enabled pending interrupt or a decrementer event returns the core to a normal mode; the mode it lands in depends on where it slept and on the interrupt-wake enable. Peripheral coprocessor activity can lift doze-low to doze-high for the length of a service, after which the block drops back to doze-low by itself. On every return to a normal mode it pulses a request that software clear the select field, and for interrupt wakes (but never for decrementer-only wakes) it pulses an indication that the core must vector to the external interrupt handler.

Top module: `pwr_mode_seq`

## Requirements
- R1: After reset the mode output is normal-high (encoding 00), the divider select equals the high divide field, and core_halt, vector_ext and clr_sel are all 0.
- R2: From a normal mode, a cycle with pwr_down_req=1, lpm_sel=01 and nest_stat=0 moves the block to doze-low (11) when clk_src_sel=1 and to doze-high (10) when clk_src_sel=0; any other lpm_sel value leaves the mode unchanged. Mode encodings: 00 normal-high, 01 normal-low, 10 doze-high, 11 doze-low.
- R3: While nest_stat=1 a doze entry request is ignored and the block stays in its normal mode.
- R4: div_sel equals hi_div in normal-high and doze-high and equals lo_div in normal-low and doze-low.
- R5: A pending interrupt (irq_pending=1) wakes a doze mode only when irq_wake_en=1; otherwise the block stays in doze.
- R6: An interrupt wake from doze-high goes to normal-high; a wake from doze-low goes to normal-high when irq_wake_en=1 and to normal-low when it is 0.
- R7: dec_wake=1 wakes either doze mode regardless of irq_wake_en, with the destination rule of R6, and without asserting vector_ext.
- R8: vector_ext is a one-cycle pulse, aligned with the first cycle of the normal mode, after an enabled interrupt wake (also when dec_wake is 1 in the same cycle).
- R9: clr_sel is a one-cycle pulse aligned with the first cycle of any normal mode reached from a doze mode.
- R10: In doze-low with periph_wake_en=1 and no wake, periph_req=1 moves the block to doze-high; periph_done=1 then returns it to doze-low. With periph_wake_en=0 the request is ignored, and periph_req or periph_done have no effect in a doze-high entered directly.
- R11: core_halt is 1 exactly while the mode is a doze mode and drops in the same cycle the mode becomes normal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lpm_sel | input | 2 | Low-power select field |
| clk_src_sel | input | 1 | Clock-source select, 1 chooses doze-low |
| pwr_down_req | input | 1 | Core power-down request |
| nest_stat | input | 1 | Timer-interrupt nesting status, blocks entry when set |
| irq_wake_en | input | 1 | Interrupt wake enable |
| periph_wake_en | input | 1 | Peripheral excursion enable |
| irq_pending | input | 1 | Enabled pending interrupt from the controller |
| dec_wake | input | 1 | Decrementer wake event |
| periph_req | input | 1 | Peripheral coprocessor activity request |
| periph_done | input | 1 | Peripheral service finished |
| hi_div | input | DIV_W | Divide field for high modes |
| lo_div | input | DIV_W | Divide field for low modes |
| pwr_mode | output | 2 | Current mode |
| div_sel | output | DIV_W | Selected clock divide value |
| core_halt | output | 1 | Core halted |
| vector_ext | output | 1 | Vector to external interrupt handler |
| clr_sel | output | 1 | Request to clear the select field |

## Verification
The properties assume every input is a defined level sampled once per clock, and that the core withdraws pwr_down_req once a doze is reached, so a fresh entry after waking is a deliberate new request. The stimulus changes inputs only on the falling edge, drops the power-down request and select field in the cycle after entry, and holds the wake sources for a single cycle, so every wake, excursion and blocked entry is an isolated event whose next-cycle result the properties and bench can both name.

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq #(
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       lpm_sel,
  input  logic             clk_src_sel,
  input  logic             pwr_down_req,
  input  logic             nest_stat,
  input  logic             irq_wake_en,
  input  logic             periph_wake_en,
  input  logic             irq_pending,
  input  logic             dec_wake,
  input  logic             periph_req,
  input  logic             periph_done,
  input  logic [DIV_W-1:0] hi_div,
  input  logic [DIV_W-1:0] lo_div,
  output logic [1:0]       pwr_mode,
  output logic [DIV_W-1:0] div_sel,
  output logic             core_halt,
  output logic             vector_ext,
  output logic             clr_sel
);

  localparam logic [1:0] M_NH = 2'b00;
  localparam logic [1:0] M_NL = 2'b01;
  localparam logic [1:0] M_DH = 2'b10;
  localparam logic [1:0] M_DL = 2'b11;

  logic [1:0] mode_q, mode_d;
  logic       svc_q, svc_d;
  logic       vec_q, clr_q;

  wire enter_req = pwr_down_req && !nest_stat && (lpm_sel == 2'b01);
  wire irq_wake  = irq_pending && irq_wake_en;
  wire wake      = irq_wake || dec_wake;
  wire leaving   = mode_q[1] && !mode_d[1];

  always_comb begin
    mode_d = mode_q;
    svc_d  = svc_q;
    case (mode_q)
      M_NH, M_NL: begin
        if (enter_req) mode_d = clk_src_sel ? M_DL : M_DH;
      end
      M_DH: begin
        if (wake) begin
          mode_d = (svc_q && !irq_wake_en) ? M_NL : M_NH;
          svc_d  = 1'b0;
        end else if (svc_q && periph_done) begin
          mode_d = M_DL;
          svc_d  = 1'b0;
        end
      end
      default: begin
        if (wake) begin
          mode_d = irq_wake_en ? M_NH : M_NL;
        end else if (periph_wake_en && periph_req) begin
          mode_d = M_DH;
          svc_d  = 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= M_NH;
      svc_q  <= 1'b0;
      vec_q  <= 1'b0;
      clr_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      svc_q  <= svc_d;
      vec_q  <= leaving && irq_wake;
      clr_q  <= leaving;
    end
  end

  assign pwr_mode   = mode_q;
  assign core_halt  = mode_q[1];
  assign div_sel    = mode_q[0] ? lo_div : hi_div;
  assign vector_ext = vec_q;
  assign clr_sel    = clr_q;

endmodule

// File: rtl/pwr_mode_seq_chk.sv
module pwr_mode_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] lpm_sel,
  input logic       clk_src_sel,
  input logic       pwr_down_req,
  input logic       nest_stat,
  input logic       irq_wake_en,
  input logic       periph_wake_en,
  input logic       irq_pending,
  input logic       dec_wake,
  input logic       periph_req,
  input logic [1:0] pwr_mode,
  input logic       core_halt,
  input logic       vector_ext,
  input logic       clr_sel
);

  p_entry_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!core_halt && pwr_down_req && !nest_stat && lpm_sel == 2'b01 && clk_src_sel)
      |=> pwr_mode == 2'b11);

  p_nest_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!core_halt && nest_stat) |=> !core_halt);

  p_stay_doze_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (core_halt && !(irq_pending && irq_wake_en) && !dec_wake) |=> core_halt);

  p_low_dest_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_mode == 2'b11 && irq_pending && irq_wake_en) |=> pwr_mode == 2'b00);

  p_dec_novec_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_mode == 2'b11 && dec_wake && !irq_wake_en) |=> (pwr_mode == 2'b01 && !vector_ext));

  p_vec_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    vector_ext |-> $past(irq_pending && irq_wake_en));

  p_clr_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_sel |-> (!core_halt && $past(core_halt)));

  p_periph_up_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_mode == 2'b11 && periph_wake_en && periph_req && !(irq_pending && irq_wake_en) && !dec_wake)
      |=> pwr_mode == 2'b10);

  p_halt_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_halt) |-> $past(pwr_down_req && lpm_sel == 2'b01 && !nest_stat));

endmodule

bind pwr_mode_seq pwr_mode_seq_chk i_chk (
  .clk(clk), .rst_n(rst_n), .lpm_sel(lpm_sel), .clk_src_sel(clk_src_sel),
  .pwr_down_req(pwr_down_req), .nest_stat(nest_stat), .irq_wake_en(irq_wake_en),
  .periph_wake_en(periph_wake_en), .irq_pending(irq_pending), .dec_wake(dec_wake),
  .periph_req(periph_req), .pwr_mode(pwr_mode), .core_halt(core_halt),
  .vector_ext(vector_ext), .clr_sel(clr_sel)
);

// File: tb/test_pwr_mode_seq.sv
module test_pwr_mode_seq;
  localparam int DIV_W = 3;
  localparam logic [DIV_W-1:0] HI = 3'd2;
  localparam logic [DIV_W-1:0] LO = 3'd5;

  logic clk = 0, rst_n = 0;
  logic [1:0] lpm_sel = 0;
  logic clk_src_sel = 0, pwr_down_req = 0, nest_stat = 0, irq_wake_en = 0;
  logic periph_wake_en = 0, irq_pending = 0, dec_wake = 0, periph_req = 0, periph_done = 0;
  logic [DIV_W-1:0] hi_div = HI, lo_div = LO;
  logic [1:0] pwr_mode;
  logic [DIV_W-1:0] div_sel;
  logic core_halt, vector_ext, clr_sel;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  pwr_mode_seq #(.DIV_W(DIV_W)) i_pwr_mode_seq (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_div(input logic [1:0] m);
    return (m == 2'b01 || m == 2'b11) ? int'(LO) : int'(HI);
  endfunction

  task automatic cyc;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic quiet;
    lpm_sel = 0; clk_src_sel = 0; pwr_down_req = 0; nest_stat = 0; irq_wake_en = 0;
    periph_wake_en = 0; irq_pending = 0; dec_wake = 0; periph_req = 0; periph_done = 0;
  endtask

  task automatic do_reset;
    @(negedge clk); quiet; rst_n = 0; cyc; cyc; rst_n = 1;
  endtask

  task automatic enter(input logic low);
    lpm_sel = 2'b01; pwr_down_req = 1; clk_src_sel = low; cyc;
    quiet;
  endtask

  task automatic full_check(input string req, input logic [1:0] m, input logic vec, input logic clr);
    chk(req, pwr_mode, m);
    chk("R4", div_sel, exp_div(m));
    chk("R11", core_halt, m[1]);
    chk("R8", vector_ext, vec);
    chk("R9", clr_sel, clr);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    do_reset;
    full_check("R1", 2'b00, 0, 0);

    // R2 / R3 entry sweep
    for (int v = 0; v < 32; v++) begin
      logic [1:0] em;
      do_reset;
      lpm_sel = v[1:0]; clk_src_sel = v[2]; pwr_down_req = v[3]; nest_stat = v[4];
      em = (v[3] && v[1:0] == 2'b01 && !v[4]) ? (v[2] ? 2'b11 : 2'b10) : 2'b00;
      cyc;
      quiet;
      full_check(v[4] ? "R3" : "R2", em, 0, 0);
    end

    // R5..R9 wake sweep
    for (int v = 0; v < 16; v++) begin
      logic low, en, irq, dec, wk;
      logic [1:0] em;
      low = v[0]; en = v[1]; irq = v[2]; dec = v[3];
      do_reset;
      enter(low);
      full_check("R2", low ? 2'b11 : 2'b10, 0, 0);
      irq_wake_en = en; irq_pending = irq; dec_wake = dec;
      wk = (irq && en) || dec;
      em = !wk ? (low ? 2'b11 : 2'b10) : ((low && !en) ? 2'b01 : 2'b00);
      cyc;
      quiet;
      full_check(dec ? "R7" : (wk ? "R6" : "R5"), em, irq && en, wk);
      cyc;
      full_check("R8", em, 0, 0);
    end

    // R10 peripheral excursion
    for (int pen = 0; pen < 2; pen++) begin
      do_reset;
      enter(1);
      periph_wake_en = pen[0]; periph_req = 1;
      cyc;
      periph_req = 0;
      full_check("R10", pen ? 2'b10 : 2'b11, 0, 0);
      periph_done = 1;
      cyc;
      periph_done = 0;
      full_check("R10", 2'b11, 0, 0);
    end

    // R10 excursion interrupted by wake, and R6 destination
    do_reset;
    enter(1);
    periph_wake_en = 1; periph_req = 1; cyc;
    periph_req = 0; irq_wake_en = 1; irq_pending = 1; cyc;
    quiet;
    full_check("R6", 2'b00, 1, 1);

    // R10 requests ignored in directly entered doze-high
    do_reset;
    enter(0);
    periph_wake_en = 1; periph_req = 1; periph_done = 1; cyc;
    quiet;
    full_check("R10", 2'b10, 0, 0);

    // normal-low can re-enter doze, and nesting bit still blocks
    do_reset;
    enter(1);
    dec_wake = 1; cyc; quiet;
    full_check("R7", 2'b01, 0, 1);
    nest_stat = 1; lpm_sel = 2'b01; pwr_down_req = 1; cyc; quiet;
    full_check("R3", 2'b01, 0, 0);
    enter(0);
    full_check("R2", 2'b10, 0, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule